// File: doc/BRIEF.md
# UART Register Bank with Two-Step Divisor Loader

This block is the byte-wide register front end for a single UART. A host reaches it through a simple bus with a read enable, a write enable and a 3-bit offset. The serial transmit and receive engines sit outside this block.

For those engines, the bank holds the frame settings: parity mode, stop-bit count and end-of-byte trigger enable. It also holds the 16-bit baud divisor, which is loaded through one byte-wide offset in two writes, high byte first. The new value takes effect only once the low byte arrives.

Toward the engines, the bank issues single-cycle strobes: receive FIFO flush, transmit byte write and receive FIFO pop. It keeps a sticky parity-error flag and assembles a status byte from that flag and the engines' ready and empty indications.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the divisor output is 10415, parity mode, stop-bit select and trigger enable are 0, the parity-error flag is clear, the read data output is 0, and the divisor loader expects the high byte.
- R2: A read of offset 0 (status) places {5'b0, empty, parity_error, ready} on `rdata_o` at the clock edge that ends the read cycle. Bit 0 is ready, bit 1 is parity error and bit 2 is empty.
- R3: A one-cycle pulse on `perr_set_i` sets the sticky parity-error flag at the next edge. A write to offset 0 with bit 1 equal to 0 clears it. A write with bit 1 equal to 1 leaves it unchanged. A set pulse in the same cycle as a clearing write keeps the flag set.
- R4: A write to offset 1 (control) with bit 0 equal to 1 raises `flush_o` during that same cycle. With bit 0 equal to 0, `flush_o` stays low.
- R5: A write to offset 2 (config) loads parity mode from bits 1:0, stop-bit select from bit 2 and trigger enable from bit 3. The new values show at the next edge, and bits 7:4 are ignored.
- R6: The first write to offset 3 (divisor) stores a high byte and leaves `divisor_o` unchanged. The second write updates `divisor_o` to {high, low} at its edge and returns the loader to expecting the high byte.
- R7: A write to offset 4 (data) raises `tx_write_o` in that same cycle, with `tx_data_o` equal to the written byte.
- R8: A read of offset 4 while the FIFO is not empty raises `fifo_pop_o` in that cycle and returns `fifo_rdata_i` on `rdata_o` at the edge. When the FIFO is empty, there is no pop and `rdata_o` becomes 0.
- R9: Reads of offsets 1, 2, 3, 5, 6 and 7 return 0. Writes to offsets 5 to 7 change no configuration or divisor state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write enable for this cycle |
| rd_en_i | input | 1 | Read enable for this cycle |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Registered read data |
| tx_ready_i | input | 1 | Transmitter can accept a byte |
| fifo_empty_i | input | 1 | Receive FIFO holds no byte |
| fifo_rdata_i | input | 8 | Head byte of the receive FIFO |
| perr_set_i | input | 1 | Receiver detected a parity error |
| flush_o | output | 1 | Receive FIFO flush strobe |
| tx_write_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Byte to transmit |
| fifo_pop_o | output | 1 | Receive FIFO pop strobe |
| parity_mode_o | output | 2 | 0 none, 1 odd, 2 even |
| stop_two_o | output | 1 | 1 selects two stop bits |
| trig_en_o | output | 1 | End-of-byte trigger enable |
| divisor_o | output | 16 | Baud divisor |

## Verification
The strobes `flush_o`, `tx_write_o` and `fifo_pop_o` are combinational. The bench therefore samples them one time unit after it drives the inputs on the falling edge, before the next rising edge.

Read data, configuration, the divisor and the parity flag are registered and change at the rising edge that ends the access. The bench checks them at the following falling edge, after clearing the enables.

The divisor is checked after each of its two writes, so a premature update shows up. The parity set-versus-clear collision is driven in a single cycle.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int NUM_REGS = 5;
  localparam int OFF_STATUS  = 0;
  localparam int OFF_CONTROL = 1;
  localparam int OFF_CONFIG  = 2;
  localparam int OFF_DIVISOR = 3;
  localparam int OFF_DATA    = 4;

  typedef struct packed {
    logic       trig_en;
    logic       stop_two;
    logic [1:0] parity_mode;
  } frame_cfg_t;

  // status byte: bit0 ready, bit1 parity error, bit2 empty
  function automatic logic [7:0] status_byte(input logic ready,
                                             input logic perr,
                                             input logic empty);
    status_byte = {5'b0, empty, perr, ready};
  endfunction

  function automatic logic [15:0] div_join(input logic [7:0] hi,
                                           input logic [7:0] lo);
    div_join = {hi, lo};
  endfunction
endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] hit_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit_o[g] = (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/uart_regbank_divisor.sv
module uart_regbank_divisor #(
  parameter int          BYTE_W    = 8,
  parameter logic [15:0] DIV_RESET = 16'd10415,
  localparam int         DIV_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DIV_W-1:0]  divisor_o,
  output logic              phase_o
);
  logic [BYTE_W-1:0] hi_q;
  logic              phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      phase_q   <= 1'b0;
      divisor_o <= DIV_W'(DIV_RESET);
    end else if (load_i) begin
      if (!phase_q) begin
        hi_q    <= byte_i;
        phase_q <= 1'b1;
      end else begin
        divisor_o <= {hi_q, byte_i};
        phase_q   <= 1'b0;
      end
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/uart_regbank_status.sv
module uart_regbank_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic keep_bit_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_o <= 1'b0;
    else if (set_i)              flag_o <= 1'b1;
    else if (wr_i && !keep_bit_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int          ADDR_W    = 3,
  parameter int          BYTE_W    = 8,
  parameter logic [15:0] DIV_RESET = 16'd10415,
  localparam int         DIV_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              tx_ready_i,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W-1:0] fifo_rdata_i,
  input  logic              perr_set_i,
  output logic              flush_o,
  output logic              tx_write_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              fifo_pop_o,
  output logic [1:0]        parity_mode_o,
  output logic              stop_two_o,
  output logic              trig_en_o,
  output logic [DIV_W-1:0]  divisor_o
);
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wr_hit;
  logic                div_phase;
  logic                perr_flag;
  logic                rd_data_hit;
  frame_cfg_t          cfg_q;
  logic [BYTE_W-1:0]   rd_next;

  uart_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign wr_hit      = wr_en_i ? hit : '0;
  assign rd_data_hit = rd_en_i && hit[OFF_DATA];

  uart_regbank_divisor #(.BYTE_W(BYTE_W), .DIV_RESET(DIV_RESET)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wr_hit[OFF_DIVISOR]),
    .byte_i    (wdata_i),
    .divisor_o (divisor_o),
    .phase_o   (div_phase)
  );

  uart_regbank_status u_perr (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (perr_set_i),
    .wr_i       (wr_hit[OFF_STATUS]),
    .keep_bit_i (wdata_i[1]),
    .flag_o     (perr_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cfg_q <= '0;
    else if (wr_hit[OFF_CONFIG])  cfg_q <= frame_cfg_t'(wdata_i[3:0]);
  end

  assign parity_mode_o = cfg_q.parity_mode;
  assign stop_two_o    = cfg_q.stop_two;
  assign trig_en_o     = cfg_q.trig_en;

  assign flush_o    = wr_hit[OFF_CONTROL] && wdata_i[0];
  assign tx_write_o = wr_hit[OFF_DATA];
  assign tx_data_o  = wdata_i;
  assign fifo_pop_o = rd_data_hit && !fifo_empty_i;

  always_comb begin
    rd_next = '0;
    if (hit[OFF_STATUS])
      rd_next = BYTE_W'(status_byte(tx_ready_i, perr_flag, fifo_empty_i));
    else if (hit[OFF_DATA] && !fifo_empty_i)
      rd_next = fifo_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              fifo_empty_i,
  input logic              perr_set_i,
  input logic              fifo_pop_o,
  input logic [BYTE_W-1:0] rdata_o,
  input logic [DIV_W-1:0]  divisor_o,
  input logic [1:0]        parity_mode_o,
  input logic              stop_two_o,
  input logic              trig_en_o,
  input logic              div_phase,
  input logic              perr_flag
);
  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(OFF_DIVISOR) && !div_phase) |=> $stable(divisor_o));

  // R6
  div_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(OFF_DIVISOR) && !div_phase) |=> div_phase);

  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> !fifo_empty_i);

  // R8
  rd_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_W'(OFF_DATA) && fifo_empty_i) |=> (rdata_o == '0));

  // R3
  perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_set_i |=> perr_flag);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_W'(OFF_CONFIG)) |=> $stable({parity_mode_o, stop_two_o, trig_en_o}));
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .fifo_empty_i  (fifo_empty_i),
  .perr_set_i    (perr_set_i),
  .fifo_pop_o    (fifo_pop_o),
  .rdata_o       (rdata_o),
  .divisor_o     (divisor_o),
  .parity_mode_o (parity_mode_o),
  .stop_two_o    (stop_two_o),
  .trig_en_o     (trig_en_o),
  .div_phase     (div_phase),
  .perr_flag     (perr_flag)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;

  // config vectors: [15:8] written byte, [3:0] expected {trig, stop, parity}
  localparam logic [15:0] CFG_VEC [5] = '{
    16'h00_00, 16'h01_01, 16'h06_06, 16'hFA_0A, 16'h0F_0F
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        tx_ready = 1'b0, fifo_empty = 1'b1, perr_set = 1'b0;
  logic [7:0]  fifo_rdata = '0;
  logic        flush, tx_write, fifo_pop, stop_two, trig_en;
  logic [7:0]  tx_data;
  logic [1:0]  parity_mode;
  logic [15:0] divisor;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .tx_ready_i(tx_ready),
    .fifo_empty_i(fifo_empty), .fifo_rdata_i(fifo_rdata), .perr_set_i(perr_set),
    .flush_o(flush), .tx_write_o(tx_write), .tx_data_o(tx_data),
    .fifo_pop_o(fifo_pop), .parity_mode_o(parity_mode), .stop_two_o(stop_two),
    .trig_en_o(trig_en), .divisor_o(divisor)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
  endtask

  task automatic end_op();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; perr_set = 1'b0;
    #1;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    start_op(1'b1, 1'b0, a, d);
    end_op();
  endtask

  task automatic do_read(input logic [2:0] a);
    start_op(1'b0, 1'b1, a, 8'h00);
    end_op();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG_LIMIT) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG_LIMIT);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 divisor", divisor, 32'd10415);
    chk("R1 config", {trig_en, stop_two, parity_mode}, 0);
    chk("R1 rdata", rdata, 0);

    // R2 status assembly
    tx_ready = 1'b1; fifo_empty = 1'b1;
    do_read(3'd0);
    chk("R2 status ready+empty", rdata, 8'h05);
    tx_ready = 1'b0; fifo_empty = 1'b0;
    do_read(3'd0);
    chk("R2 status all low", rdata, 8'h00);

    // R3 sticky parity
    @(negedge clk); perr_set = 1'b1;
    @(negedge clk); perr_set = 1'b0;
    do_read(3'd0);
    chk("R3 perr set", rdata, 8'h02);
    do_write(3'd0, 8'h02);
    do_read(3'd0);
    chk("R3 write 1 keeps", rdata, 8'h02);
    do_write(3'd0, 8'h00);
    do_read(3'd0);
    chk("R3 write 0 clears", rdata, 8'h00);
    @(negedge clk); perr_set = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h00;
    end_op();
    do_read(3'd0);
    chk("R3 set wins over clear", rdata, 8'h02);
    do_write(3'd0, 8'h00);

    // R4 flush strobe
    start_op(1'b1, 1'b0, 3'd1, 8'h01);
    chk("R4 flush on bit0", flush, 1);
    end_op();
    start_op(1'b1, 1'b0, 3'd1, 8'hFE);
    chk("R4 no flush bit0 zero", flush, 0);
    end_op();

    // R5 config table
    for (int i = 0; i < 5; i++) begin
      do_write(3'd2, CFG_VEC[i][15:8]);
      chk("R5 config fields", {trig_en, stop_two, parity_mode}, CFG_VEC[i][3:0]);
    end

    // R6 divisor two-step load
    do_write(3'd3, 8'h12);
    chk("R6 unchanged after high byte", divisor, 32'd10415);
    do_write(3'd3, 8'h34);
    chk("R6 loaded", divisor, 32'h1234);
    do_write(3'd3, 8'h00);
    chk("R6 hold second load", divisor, 32'h1234);
    do_write(3'd3, 8'h01);
    chk("R6 loaded min", divisor, 32'h0001);

    // R7 transmit write
    fifo_empty = 1'b0;
    start_op(1'b1, 1'b0, 3'd4, 8'h5A);
    chk("R7 tx strobe", tx_write, 1);
    chk("R7 tx data", tx_data, 8'h5A);
    chk("R7 no pop on write", fifo_pop, 0);
    end_op();
    chk("R7 strobe ends", tx_write, 0);

    // R8 data read
    fifo_rdata = 8'hA5; fifo_empty = 1'b0;
    start_op(1'b0, 1'b1, 3'd4, 8'h00);
    chk("R8 pop nonempty", fifo_pop, 1);
    end_op();
    chk("R8 rdata head", rdata, 8'hA5);
    fifo_empty = 1'b1;
    start_op(1'b0, 1'b1, 3'd4, 8'h00);
    chk("R8 no pop empty", fifo_pop, 0);
    end_op();
    chk("R8 rdata empty", rdata, 8'h00);

    // R9 other offsets
    fifo_empty = 1'b0;
    do_read(3'd0);
    do_read(3'd3);
    chk("R9 read divisor offset", rdata, 8'h00);
    do_read(3'd0);
    do_read(3'd6);
    chk("R9 read offset 6", rdata, 8'h00);
    do_write(3'd6, 8'hFF);
    do_write(3'd7, 8'hFF);
    chk("R9 divisor untouched", divisor, 32'h0001);
    chk("R9 config untouched", {trig_en, stop_two, parity_mode}, 4'hF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule